// File: doc/BRIEF.md
# Core-Rail Standby Monitor

This block watches an already digitized core-supply voltage so that a fan and thermal controller can tell when the host has gone into a deep sleep state. Each time a new 8-bit sample is flagged valid, the block compares it with a programmable low limit. A sample under the limit latches a sticky status flag. If alerting is enabled, the flag also drives an active-low, open-drain-style alert request. The same condition suspends monitoring of the thermal-throttle input.

While monitoring is suspended, the throttle-duration timer keeps its count instead of clearing. The first valid sample at or above the limit re-arms monitoring, and the timer then continues from the value it held. The timer advances once per tick-enable pulse while the synchronized throttle input is high, and it stops at all ones. Software clears the status flag with a read-clear pulse, which works only once the supply has recovered.

Top module: `core_rail_standby_mon`

## Requirements
- R1: A sample is below the limit when `smp_code < low_limit` (unsigned), evaluated only in a cycle with `smp_valid` high. Such a sample sets `rail_low_sts` at the next clock edge. A sample equal to the limit is not low.
- R2: `rail_low_sts` is sticky. Later valid samples at or above the limit do not clear it.
- R3: A `status_rd_clr` pulse clears `rail_low_sts` at the next edge only if the most recent valid sample was not below the limit and the current cycle carries no new low sample. Otherwise the pulse is ignored.
- R4: `alert_n` is 0 exactly while `rail_low_sts` is 1 and `alert_en` is 1, and it reacts to `alert_en` in the same cycle. It returns to 1 when the status clears.
- R5: From the edge that captures a low sample until the edge that captures a sample at or above the limit, `throttle_time` holds its value, whatever `throttle_raw` and `tick_en` do.
- R6: Once a sample at or above the limit has been captured, counting resumes from the held value, with no clear.
- R7: While monitoring is enabled, `throttle_time` rises by exactly one on each cycle with `tick_en` high and the synchronized throttle high. `throttle_raw` passes through a two-flop synchronizer, so a change at the input first affects counting two edges later.
- R8: `throttle_time` saturates at all ones and stays there while ticks continue.
- R9: While `rst_n` is low at a clock edge, `rail_low_sts` goes to 0, `throttle_time` goes to 0 and monitoring becomes enabled, so `alert_n` is 1.
- R10: When `smp_valid` is low, `smp_code` has no effect on the status flag or on the monitoring state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Strobe that marks `smp_code` as a new sample |
| smp_code | input | SAMPLE_W | Unsigned core-voltage code |
| low_limit | input | SAMPLE_W | Programmed low limit |
| alert_en | input | 1 | Allows the status flag to drive the alert |
| status_rd_clr | input | 1 | Read-clear pulse for the status flag |
| throttle_raw | input | 1 | Asynchronous thermal-throttle input, active high |
| tick_en | input | 1 | Time-base pulse for the duration timer |
| rail_low_sts | output | 1 | Sticky low-rail status flag |
| alert_n | output | 1 | Active-low alert request |
| throttle_time | output | TIMER_W | Accumulated throttle duration, saturating |

## Verification
A sample presented with `smp_valid` shows up on `rail_low_sts` one edge later. A read-clear likewise takes effect one edge later. `alert_n` follows the status flag and `alert_en` in the same cycle. A change on `throttle_raw` needs two edges to pass the synchronizer before a tick can count it on the third. The bench drives inputs on the falling edge and samples outputs on the next falling edge. It waits three full cycles after every throttle change before issuing ticks, so each tick cycle adds exactly one count. The timer is given a narrow width in the bench so that saturation is reached within a few dozen ticks.

// File: rtl/crsm_pkg.sv
// Package: crsm_pkg
// Holds the types shared by the core-rail standby monitor modules.
// Assumes nothing beyond a single clock domain for its users.
package crsm_pkg;
    // State of the core rail as seen by the last valid sample.
    typedef enum logic {
        RAIL_OK  = 1'b0,
        RAIL_LOW = 1'b1
    } rail_state_e;
endpackage

// File: rtl/crsm_rail_cmp.sv
// Module: crsm_rail_cmp
// Compares each valid sample with the low limit. It gives a same-cycle
// low-sample pulse and the registered rail state, which gates monitoring.
// Assumes unsigned codes and a synchronous active-low reset.
module crsm_rail_cmp
    import crsm_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_code,
    input  logic [SAMPLE_W-1:0] low_limit,
    output logic                low_event,
    output logic                rail_low_q
);
    rail_state_e state_q;

    // Flag a valid sample that falls under the limit.
    always_comb low_event = smp_valid && (smp_code < low_limit);

    // Track rail state; only valid samples may move it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RAIL_OK;
        else if (smp_valid)
            state_q <= low_event ? RAIL_LOW : RAIL_OK;
    end

    // Expose the state as a plain bit.
    always_comb rail_low_q = (state_q == RAIL_LOW);
endmodule

// File: rtl/crsm_status.sv
// Module: crsm_status
// Sticky low-rail flag with a guarded read-clear, plus alert gating.
// Assumes low_event and rail_low_q come from crsm_rail_cmp in the same domain.
module crsm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic low_event,
    input  logic rail_low_q,
    input  logic rd_clr,
    input  logic alert_en,
    output logic sts_q,
    output logic alert_n
);
    logic clr_ok;

    // A clear counts only when no low condition is present now.
    always_comb clr_ok = rd_clr && !rail_low_q && !low_event;

    // Set on a low sample, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= 1'b0;
        else if (low_event)
            sts_q <= 1'b1;
        else if (clr_ok)
            sts_q <= 1'b0;
    end

    // Open-drain-style alert: pulled low while the flag is set and enabled.
    always_comb alert_n = !(sts_q && alert_en);
endmodule

// File: rtl/crsm_thr_timer.sv
// Module: crsm_thr_timer
// Synchronizes the raw throttle input and accumulates enabled ticks while
// it is high. It holds the count while monitoring is suspended and
// saturates at all ones.
// Assumes SYNC_STAGES >= 2 and tick_en is a one-cycle time-base pulse.
module crsm_thr_timer #(
    parameter int TIMER_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               throttle_raw,
    input  logic               tick_en,
    input  logic               suspend,
    output logic [TIMER_W-1:0] count_q
);
    localparam logic [TIMER_W-1:0] CNT_MAX = '1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   thr_s;
    logic                   step;

    // Bring the asynchronous throttle input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], throttle_raw};
    end

    // Take the synchronized throttle from the last stage.
    always_comb thr_s = sync_q[SYNC_STAGES-1];

    // Decide whether this cycle adds one to the count.
    always_comb step = tick_en && thr_s && !suspend && (count_q != CNT_MAX);

    // Accumulate throttle time; hold while suspended or saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (step)
            count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/core_rail_standby_mon.sv
// Module: core_rail_standby_mon
// Top of the core-rail standby monitor. It ties the rail comparator, the
// sticky status and alert, and the throttle timer, which is suspended
// while the rail is low.
// Assumes an ADC and a register interface outside the block.
module core_rail_standby_mon #(
    parameter int SAMPLE_W    = 8,
    parameter int TIMER_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_code,
    input  logic [SAMPLE_W-1:0] low_limit,
    input  logic                alert_en,
    input  logic                status_rd_clr,
    input  logic                throttle_raw,
    input  logic                tick_en,
    output logic                rail_low_sts,
    output logic                alert_n,
    output logic [TIMER_W-1:0]  throttle_time
);
    logic low_event;
    logic rail_low_q;

    crsm_rail_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_code   (smp_code),
        .low_limit  (low_limit),
        .low_event  (low_event),
        .rail_low_q (rail_low_q)
    );

    crsm_status u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .low_event  (low_event),
        .rail_low_q (rail_low_q),
        .rd_clr     (status_rd_clr),
        .alert_en   (alert_en),
        .sts_q      (rail_low_sts),
        .alert_n    (alert_n)
    );

    crsm_thr_timer #(.TIMER_W(TIMER_W), .SYNC_STAGES(SYNC_STAGES)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .throttle_raw (throttle_raw),
        .tick_en      (tick_en),
        .suspend      (rail_low_q),
        .count_q      (throttle_time)
    );
endmodule

// File: rtl/core_rail_standby_mon_chk.sv
// Module: core_rail_standby_mon_chk
// Assertion checker bound into core_rail_standby_mon. It observes the ports
// and the internal rail state. It assumes a synchronous active-low reset.
module core_rail_standby_mon_chk #(
    parameter int SAMPLE_W = 8,
    parameter int TIMER_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_code,
    input logic [SAMPLE_W-1:0] low_limit,
    input logic                alert_en,
    input logic                status_rd_clr,
    input logic                rail_low_sts,
    input logic                alert_n,
    input logic [TIMER_W-1:0]  throttle_time,
    input logic                rail_low_q
);
    localparam logic [TIMER_W-1:0] T_MAX = '1;

    a_r1_low_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (smp_code < low_limit)) |=> rail_low_sts);

    a_r2_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_low_sts && !status_rd_clr) |=> rail_low_sts);

    a_r3_clear_blocked_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_low_sts && rail_low_q) |=> rail_low_sts);

    a_r4_alert_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_low_sts |-> alert_n);

    a_r5_timer_holds_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        rail_low_q |=> $stable(throttle_time));

    a_r7_timer_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((throttle_time == $past(throttle_time)) ||
                  (throttle_time == $past(throttle_time) + 1'b1)));

    a_r8_timer_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_time == T_MAX) |=> (throttle_time == T_MAX));

    a_r10_no_valid_no_state_change: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(rail_low_q));
endmodule

bind core_rail_standby_mon core_rail_standby_mon_chk #(
    .SAMPLE_W (SAMPLE_W),
    .TIMER_W  (TIMER_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_valid     (smp_valid),
    .smp_code      (smp_code),
    .low_limit     (low_limit),
    .alert_en      (alert_en),
    .status_rd_clr (status_rd_clr),
    .rail_low_sts  (rail_low_sts),
    .alert_n       (alert_n),
    .throttle_time (throttle_time),
    .rail_low_q    (rail_low_q)
);

// File: tb/sim_core_rail_standby_mon.sv
`timescale 1ns/1ps
// Bench: sim_core_rail_standby_mon
// Directed tests, one task per scenario. Inputs are driven on the falling
// edge and outputs are sampled on the falling edge that follows.
module sim_core_rail_standby_mon;
    localparam int SW = 8;
    localparam int TW = 6;
    localparam logic [TW-1:0] TMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_code = '0;
    logic [SW-1:0] low_limit = 8'd100;
    logic          alert_en = 1'b0;
    logic          status_rd_clr = 1'b0;
    logic          throttle_raw = 1'b0;
    logic          tick_en = 1'b0;
    logic          rail_low_sts;
    logic          alert_n;
    logic [TW-1:0] throttle_time;

    int checks = 0;
    int failures = 0;
    int exp_t = 0;

    always #10 clk = ~clk;

    core_rail_standby_mon #(.SAMPLE_W(SW), .TIMER_W(TW), .SYNC_STAGES(2)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid     (smp_valid),
        .smp_code      (smp_code),
        .low_limit     (low_limit),
        .alert_en      (alert_en),
        .status_rd_clr (status_rd_clr),
        .throttle_raw  (throttle_raw),
        .tick_en       (tick_en),
        .rail_low_sts  (rail_low_sts),
        .alert_n       (alert_n),
        .throttle_time (throttle_time)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One valid sample; the result is visible at the next falling edge.
    task automatic send(input logic [SW-1:0] code);
        smp_code  = code;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic rd_clear();
        status_rd_clr = 1'b1;
        @(negedge clk);
        status_rd_clr = 1'b0;
    endtask

    task automatic set_thr(input logic v);
        throttle_raw = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_t = 0;
        chk(rail_low_sts == 1'b0, "R9 status", rail_low_sts, 0);
        chk(alert_n == 1'b1, "R9 alert_n", alert_n, 1);
        chk(throttle_time == 0, "R9 timer", throttle_time, 0);
    endtask

    task automatic t_compare();
        send(8'd100);
        chk(rail_low_sts == 1'b0, "R1 equal not low", rail_low_sts, 0);
        smp_code = 8'd3;
        repeat (3) @(negedge clk);
        chk(rail_low_sts == 1'b0, "R10 no valid ignored", rail_low_sts, 0);
        send(8'd99);
        chk(rail_low_sts == 1'b1, "R1 below sets", rail_low_sts, 1);
        send(8'd200);
        chk(rail_low_sts == 1'b1, "R2 sticky", rail_low_sts, 1);
        rd_clear();
        chk(rail_low_sts == 1'b0, "R3 clear after recovery", rail_low_sts, 0);
    endtask

    task automatic t_clear_blocked();
        send(8'd10);
        rd_clear();
        chk(rail_low_sts == 1'b1, "R3 clear ignored while low", rail_low_sts, 1);
        // A low sample together with a clear: the set wins.
        send(8'd150);
        smp_code = 8'd5; smp_valid = 1'b1; status_rd_clr = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; status_rd_clr = 1'b0;
        chk(rail_low_sts == 1'b1, "R3 clear ignored with new low", rail_low_sts, 1);
        send(8'd150);
        rd_clear();
        chk(rail_low_sts == 1'b0, "R3 clear works", rail_low_sts, 0);
    endtask

    task automatic t_alert();
        alert_en = 1'b0;
        send(8'd1);
        chk(alert_n == 1'b1, "R4 disabled no alert", alert_n, 1);
        alert_en = 1'b1;
        #1;
        chk(alert_n == 1'b0, "R4 enabled alert", alert_n, 0);
        send(8'd120);
        rd_clear();
        chk(alert_n == 1'b1, "R4 alert released on clear", alert_n, 1);
        alert_en = 1'b0;
    endtask

    task automatic t_count();
        ticks(4);
        chk(throttle_time == exp_t, "R7 no throttle no count", throttle_time, exp_t);
        throttle_raw = 1'b1;
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        chk(throttle_time == exp_t, "R7 synchronizer delay", throttle_time, exp_t);
        @(negedge clk);
        ticks(5);
        exp_t += 5;
        chk(throttle_time == exp_t, "R7 counts ticks", throttle_time, exp_t);
        repeat (4) @(negedge clk);
        chk(throttle_time == exp_t, "R7 no tick no count", throttle_time, exp_t);
    endtask

    task automatic t_hold_resume();
        send(8'd20);
        ticks(6);
        chk(throttle_time == exp_t, "R5 hold while low", throttle_time, exp_t);
        set_thr(1'b0);
        set_thr(1'b1);
        ticks(2);
        chk(throttle_time == exp_t, "R5 still held", throttle_time, exp_t);
        send(8'd180);
        ticks(3);
        exp_t += 3;
        chk(throttle_time == exp_t, "R6 resume from held", throttle_time, exp_t);
        rd_clear();
    endtask

    task automatic t_saturate();
        ticks(70);
        chk(throttle_time == TMAX, "R8 saturates", throttle_time, TMAX);
        ticks(5);
        chk(throttle_time == TMAX, "R8 stays at max", throttle_time, TMAX);
        set_thr(1'b0);
        t_reset();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_compare();
        t_clear_blocked();
        t_alert();
        t_count();
        t_hold_resume();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule